// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block gathers the interrupt sources of a PCIe root port into a single 32-bit status word and raises one level-sensitive interrupt line for the host. Six event sources arrive as single-cycle pulses. Each pulse sets a sticky status bit, and software clears that bit by writing a one to it. Four legacy INTx wires arrive as levels. They pass through a synchronizer, and their status bits then follow the wire directly.

Software does not write the mask register directly. One register sets mask bits and a second register clears them. In both registers only the bits written as one take effect. A source interrupts only while its status bit is set and its mask bit is clear. The register port is synchronous for writes and gives combinational read data for the address that is presented.

Top module: `irq_status_mask_ctl`

## Requirements
- R1: After reset, status reads 0, the mask reads 0x1F558000 (every defined source masked), and `irq_out` is 0.
- R2: An event pulse sets its status bit, and the bit holds until it is cleared. The bit positions are: completion timeout 15, PME message 24, PME turn-off acknowledge 25, correctable error 26, non-fatal error 27, fatal error 28.
- R3: A write to status (offset 0x4C0) clears each event bit written as 1. Bits written as 0 are unchanged.
- R4: When an event pulse and a clear of the same bit fall in one cycle, the bit stays set.
- R5: INTx line n (0..3) appears at status bit 16+2n two clock edges after the input changes. Clear writes have no effect on these bits.
- R6: A write to offset 0x4CC sets the mask bit of each defined source written as 1. Bits written as 0 are unchanged.
- R7: A write to offset 0x4C8 clears the mask bit of each defined source written as 1. Bits written as 0 are unchanged.
- R8: Offset 0x4C4 reads the mask, with 1 meaning masked. Offsets 0x4C8, 0x4CC and any unmapped address read 0.
- R9: Bit positions outside the defined source set always read 0 in status and mask, and writes to them are ignored.
- R10: `irq_out` is 1 exactly while some status bit is set whose mask bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 12 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| ev_cpl_timeout | input | 1 | Completion timeout pulse |
| ev_pme_msg | input | 1 | PME message received pulse |
| ev_pme_ack | input | 1 | PME turn-off acknowledge pulse |
| ev_err_cor | input | 1 | Correctable error message pulse |
| ev_err_nonfatal | input | 1 | Non-fatal error message pulse |
| ev_err_fatal | input | 1 | Fatal error message pulse |
| intx_in | input | 4 | Legacy INTx levels, bit n is INTx n |
| irq_out | output | 1 | Level interrupt to the host |

## Verification
An event pulse and a software clear of the same status bit can land on the same clock edge. A change on an INTx line can also land on the same edge as a clear write that covers its bit. The bench forces both collisions on purpose. It drives the fatal-error pulse in the same cycle as a write of one to bit 28, and it holds INTx C high while writing one to bit 20. It expects both bits to stay set. Randomized traffic then makes pulses, clears, and enable or disable writes overlap at random. A behavioural model is compared against the outputs on every clock.

// File: rtl/irq_status_mask_ctl.sv
module irq_status_mask_ctl #(
  parameter int ADDR_W      = 12,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int NUM_INTX    = 4,
  parameter logic [ADDR_W-1:0] OFS_STATUS = 12'h4C0,
  parameter logic [ADDR_W-1:0] OFS_MASK   = 12'h4C4,
  parameter logic [ADDR_W-1:0] OFS_ENABLE = 12'h4C8,
  parameter logic [ADDR_W-1:0] OFS_DISABLE = 12'h4CC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              ev_cpl_timeout,
  input  logic              ev_pme_msg,
  input  logic              ev_pme_ack,
  input  logic              ev_err_cor,
  input  logic              ev_err_nonfatal,
  input  logic              ev_err_fatal,
  input  logic [NUM_INTX-1:0] intx_in,
  output logic              irq_out
);

  localparam int INTX_BASE = 16;
  localparam int BIT_CTO   = 15;
  localparam int BIT_PME   = 24;
  localparam int BIT_ACK   = 25;
  localparam int BIT_COR   = 26;
  localparam int BIT_NFE   = 27;
  localparam int BIT_FAT   = 28;

  function automatic logic [DATA_W-1:0] intx_place(input logic [NUM_INTX-1:0] v);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int n = 0; n < NUM_INTX; n++) r[INTX_BASE + 2*n] = v[n];
    return r;
  endfunction

  localparam logic [DATA_W-1:0] EVT_BITS =
    (DATA_W'(1) << BIT_CTO) | (DATA_W'(1) << BIT_PME) | (DATA_W'(1) << BIT_ACK) |
    (DATA_W'(1) << BIT_COR) | (DATA_W'(1) << BIT_NFE) | (DATA_W'(1) << BIT_FAT);
  localparam logic [DATA_W-1:0] INTX_BITS = intx_place('1);
  localparam logic [DATA_W-1:0] DEF_BITS  = EVT_BITS | INTX_BITS;

  logic [DATA_W-1:0] evt_vec, ev_q, mask_q, status;
  logic [NUM_INTX-1:0] sync_q [SYNC_STAGES];

  always_comb begin
    evt_vec = '0;
    evt_vec[BIT_CTO] = ev_cpl_timeout;
    evt_vec[BIT_PME] = ev_pme_msg;
    evt_vec[BIT_ACK] = ev_pme_ack;
    evt_vec[BIT_COR] = ev_err_cor;
    evt_vec[BIT_NFE] = ev_err_nonfatal;
    evt_vec[BIT_FAT] = ev_err_fatal;
  end

  wire wr_status  = wr_en && (addr == OFS_STATUS);
  wire wr_enable  = wr_en && (addr == OFS_ENABLE);
  wire wr_disable = wr_en && (addr == OFS_DISABLE);
  wire [DATA_W-1:0] clr_vec = wr_status ? (wdata & EVT_BITS) : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ev_q <= '0;
    else        ev_q <= (ev_q & ~clr_vec) | evt_vec;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          mask_q <= DEF_BITS;
    else if (wr_disable) mask_q <= mask_q | (wdata & DEF_BITS);
    else if (wr_enable)  mask_q <= mask_q & ~(wdata & DEF_BITS);

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sync_q[s] <= '0;
      else        sync_q[s] <= (s == 0) ? intx_in : sync_q[(s == 0) ? 0 : s-1];
  end

  assign status  = ev_q | intx_place(sync_q[SYNC_STAGES-1]);
  assign irq_out = |(status & ~mask_q);
  assign rdata   = (addr == OFS_STATUS) ? status :
                   (addr == OFS_MASK)   ? mask_q : '0;

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mask_q == DEF_BITS && ev_q == '0));

  // R4
  pulse_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vec != '0) |=> ((ev_q & $past(evt_vec)) == $past(evt_vec)));

  // R3
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && evt_vec == '0) |=> ((ev_q & $past(wdata) & EVT_BITS) == '0));

  // R6
  disable_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_disable |=> ((mask_q & $past(wdata) & DEF_BITS) == ($past(wdata) & DEF_BITS)));

  // R7
  enable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_enable |=> ((mask_q & $past(wdata)) == '0));

endmodule

// File: tb/test_irq_status_mask_ctl.sv
module test_irq_status_mask_ctl;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [5:0] ev = '0;
  logic [3:0] intx = '0;
  logic irq_out;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  irq_status_mask_ctl i_irq_status_mask_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .ev_cpl_timeout(ev[0]), .ev_pme_msg(ev[1]), .ev_pme_ack(ev[2]),
    .ev_err_cor(ev[3]), .ev_err_nonfatal(ev[4]), .ev_err_fatal(ev[5]),
    .intx_in(intx), .irq_out(irq_out));

  int ev_pos [6] = '{15, 24, 25, 26, 27, 28};
  logic [31:0] m_ev, m_mask;
  logic [3:0] m_pipe [$];
  localparam logic [31:0] DEFS = 32'h1F558000;

  function automatic logic [31:0] m_status();
    logic [31:0] r = m_ev;
    for (int n = 0; n < 4; n++) r[16 + 2*n] = m_pipe[0][n];
    return r;
  endfunction

  function automatic logic [31:0] m_read(input logic [11:0] a);
    if (a == 12'h4C0) return m_status();
    if (a == 12'h4C4) return m_mask;
    return '0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ev = '0; m_mask = DEFS; m_pipe = {4'h0, 4'h0};
  endtask

  task automatic model_step();
    logic [31:0] evv = '0;
    for (int i = 0; i < 6; i++) evv[ev_pos[i]] = ev[i];
    if (wr_en && addr == 12'h4C0) m_ev = m_ev & ~(wdata & 32'h1F008000);
    m_ev = m_ev | evv;
    if (wr_en && addr == 12'h4CC) m_mask = m_mask | (wdata & DEFS);
    if (wr_en && addr == 12'h4C8) m_mask = m_mask & ~(wdata & DEFS);
    m_pipe.push_back(intx);
    void'(m_pipe.pop_front());
  endtask

  // one clock: inputs already driven; compare after edge
  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    wr_en = 0; ev = '0;
    #1;
    chk("R10 irq", {31'b0, irq_out}, {31'b0, |(m_status() & ~m_mask)});
    chk(addr == 12'h4C0 ? "R2 status" : addr == 12'h4C4 ? "R8 mask" : "R9 other",
        rdata, m_read(addr));
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1; addr = a; wdata = d; cyc();
  endtask

  task automatic rd(input logic [11:0] a, input string tag, input logic [31:0] exp);
    addr = a; #1; chk(tag, rdata, exp);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    rd(12'h4C0, "R1 status", 32'h0);
    rd(12'h4C4, "R1 mask", 32'h1F558000);
    chk("R1 irq", {31'b0, irq_out}, 32'h0);

    // R2: each event while masked
    ev = 6'b111111; cyc();
    rd(12'h4C0, "R2 all events", 32'h1F008000);
    chk("R10 masked irq", {31'b0, irq_out}, 32'h0);
    repeat (3) cyc();
    rd(12'h4C0, "R2 sticky", 32'h1F008000);

    // R7 and R9: enable all, undefined bits ignored
    wr(12'h4C8, 32'hFFFFFFFF);
    rd(12'h4C4, "R7 enable all", 32'h0);
    chk("R10 unmasked irq", {31'b0, irq_out}, 32'h1);

    // R3
    wr(12'h4C0, 32'h00008000);
    rd(12'h4C0, "R3 clear one", 32'h1F000000);

    // R4: pulse and clear in the same cycle
    ev = 6'b100000; wr(12'h4C0, 32'h10000000);
    rd(12'h4C0, "R4 collision", 32'h1F000000);
    wr(12'h4C0, 32'hFFFFFFFF);
    rd(12'h4C0, "R3 clear all", 32'h0);
    chk("R10 idle irq", {31'b0, irq_out}, 32'h0);

    // R5: INTx C at bit 20 after two edges, clear ignored
    intx = 4'b0100; cyc();
    rd(12'h4C0, "R5 one edge", 32'h0);
    cyc();
    rd(12'h4C0, "R5 two edges", 32'h00100000);
    wr(12'h4C0, 32'h00100000);
    rd(12'h4C0, "R5 clear ignored", 32'h00100000);
    chk("R10 intx irq", {31'b0, irq_out}, 32'h1);

    // R6
    wr(12'h4CC, 32'h00100000);
    rd(12'h4C4, "R6 disable one", 32'h00100000);
    chk("R6 irq masked", {31'b0, irq_out}, 32'h0);
    wr(12'h4CC, 32'h0);
    rd(12'h4C4, "R6 zero write", 32'h00100000);
    wr(12'h4CC, 32'hE0000001);
    rd(12'h4C4, "R9 undefined write", 32'h00100000);

    // R8
    rd(12'h4C8, "R8 enable reads zero", 32'h0);
    rd(12'h4CC, "R8 disable reads zero", 32'h0);
    rd(12'h000, "R8 unmapped", 32'h0);
    intx = 4'b0000; repeat (2) cyc();

    // mixed traffic against model
    for (int k = 0; k < 2000; k++) begin
      logic [2:0] sel = 3'($urandom_range(0, 4));
      addr = (sel == 0) ? 12'h4C0 : (sel == 1) ? 12'h4C4 : (sel == 2) ? 12'h4C8 :
             (sel == 3) ? 12'h4CC : 12'h100;
      wr_en = ($urandom_range(0, 3) == 0);
      wdata = $urandom();
      ev = 6'($urandom()) & 6'($urandom());
      if ($urandom_range(0, 7) == 0) intx = 4'($urandom());
      cyc();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule